// File: doc/BRIEF.md
# SMBus host status register

This block is the 8-bit host status register of an SMBus host controller, as seen through a plain register read/write port. It keeps four live flags. The byte-done flag lets software step through a block transfer one byte at a time. The completion interrupt flag marks the end of a command. The alert flag records that the bus alert line raised an interrupt. The in-use flag is a software semaphore that claims itself when it is read. Every hardware-owned flag is set by an event strobe from the transfer engine and is cleared only when software writes a 1 to its bit. Hardware flags drive a single interrupt request line.

Two state machines sit beside the flag bits. The completion sequencer has two states. In `SEQ_IDLE` it waits; it moves to `SEQ_HOLD` when the last byte of a block arrives, because the completion interrupt is then held back. In `SEQ_HOLD` it waits for software to clear byte-done; on that clear it returns to `SEQ_IDLE` and releases the completion interrupt. So an n-byte block raises n+1 interrupts. The semaphore machine also has two states. It moves from `SEM_FREE` to `SEM_TAKEN` on any read of the register, and from `SEM_TAKEN` back to `SEM_FREE` when software writes 1 to the in-use bit.

There are two reset domains. The resume-well reset clears everything. The platform reset clears everything except the alert flag. A warm-reset request clears everything, the alert flag included. Bit positions: 7 byte-done, 6 in-use, 5 alert, 1 completion interrupt. Bits 4, 3, 2 and 0 read 0.

Top module: `smb_hsts_reg`

## Requirements
- R1: After the resume-well reset, a read of offset 00h returns 00h and `irq` is low.
- R2: A byte event during a block transfer sets bit 7 at the next clock edge, provided the buffer is disabled and the transfer is not a heartbeat. This includes the final byte.
- R3: A byte event leaves bit 7 unchanged while `buf_en` or `hb_xfer` is high.
- R4: A write to offset 00h clears each of bits 7, 5 and 1 where the write data holds a 1, and leaves the bit alone where it holds a 0. Writes to any other offset change nothing.
- R5: A byte event flagged `last_byte` sets bit 7 but not bit 1 (`SEQ_IDLE` to `SEQ_HOLD`). The write that clears bit 7 in `SEQ_HOLD` sets bit 1 at that same edge (`SEQ_HOLD` to `SEQ_IDLE`).
- R6: `done_evt` sets bit 1 at the next edge.
- R7: Bit 6 reads 0 on the first read after reset. Every read of offset 00h makes bit 6 read 1 from the next cycle on (`SEM_FREE` to `SEM_TAKEN`). Writing 1 to bit 6 makes it read 0 again (`SEM_TAKEN` to `SEM_FREE`).
- R8: Bit 6 affects neither `irq` nor any other status bit.
- R9: `alert_int` sets bit 5 at the next edge, unless `alert_gpi` is high, in which case bit 5 stays clear.
- R10: Bit 5 survives `plat_rst_n` low, which clears bits 7, 6 and 1 and both state machines. `warm_rst_req` clears all bits.
- R11: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set. A read and a write-1 to bit 6 in the same cycle likewise leave it set.
- R12: `irq` equals `gie` AND (bit 7 OR bit 5 OR bit 1).
- R13: `reg_rdata` is 00h whenever no read of offset 00h is being made. Bits 4, 3, 2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rsm_rst_n | input | 1 | Resume-well reset, asynchronous, active low, clears all |
| plat_rst_n | input | 1 | Platform reset, synchronous, active low, keeps the alert flag |
| warm_rst_req | input | 1 | Warm-reset request pulse, clears all flags |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational in the read cycle |
| byte_evt | input | 1 | One byte sent or received |
| blk_xfer | input | 1 | Current command is a block transfer |
| last_byte | input | 1 | The byte event is the last of the block |
| buf_en | input | 1 | 32-byte buffer enabled |
| hb_xfer | input | 1 | Transfer belongs to the LAN heartbeat |
| done_evt | input | 1 | Command completed |
| alert_int | input | 1 | Alert line caused an interrupt |
| alert_gpi | input | 1 | Alert pin configured as general-purpose input |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Two functions that can land in the same cycle are a hardware set and a software write-1 clear of one flag. Examples are a byte event together with a clear of bit 7, `done_evt` with a clear of bit 1, `alert_int` with a clear of bit 5, and a semaphore read with a write of 1 to bit 6. The bench drives each pair in a single cycle and reads the register on the following cycle. The behavioural model applies the clear first and the set second, and it is compared against `reg_rdata` and `irq` on every clock. The sequencer release is also provoked while a new byte event is pending, so that a clear which loses must not release the completion interrupt.

// File: rtl/smb_hsts_pkg.sv
`timescale 1ns/1ps
package smb_hsts_pkg;
    localparam int STAT_W    = 8;
    localparam int POS_BD    = 7;
    localparam int POS_INUSE = 6;
    localparam int POS_ALERT = 5;
    localparam int POS_INTR  = 1;

    localparam int N_STICKY  = 3;
    localparam int IDX_BD    = 0;
    localparam int IDX_ALERT = 1;
    localparam int IDX_INTR  = 2;

    typedef enum logic {SEQ_IDLE, SEQ_HOLD} seq_state_e;
    typedef enum logic {SEM_FREE, SEM_TAKEN} sem_state_e;
endpackage

// File: rtl/smb_hsts_sticky.sv
`timescale 1ns/1ps
module smb_hsts_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_clr,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // A reset clear beats everything; after that a set beats a software clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q_o <= 1'b0;
        else if (sync_clr) q_o <= 1'b0;
        else if (set_i)    q_o <= 1'b1;
        else if (clr_i)    q_o <= 1'b0;
    end
endmodule

// File: rtl/smb_hsts_seq.sv
`timescale 1ns/1ps
module smb_hsts_seq
    import smb_hsts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_clr,
    input  logic last_set_i,
    input  logic bd_set_i,
    input  logic bd_clr_i,
    output logic release_o,
    output logic hold_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= SEQ_IDLE;
        else if (sync_clr) state_q <= SEQ_IDLE;
        else               state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (last_set_i)             state_d = SEQ_HOLD;
            SEQ_HOLD: if (bd_clr_i && !bd_set_i)  state_d = SEQ_IDLE;
            default:                              state_d = SEQ_IDLE;
        endcase
    end

    // The release fires only when the clear of byte-done actually takes effect.
    always_comb begin
        hold_o    = (state_q == SEQ_HOLD);
        release_o = (state_q == SEQ_HOLD) && bd_clr_i && !bd_set_i;
    end

    assert_hold_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HOLD && !sync_clr && bd_set_i) |=> (state_q == SEQ_HOLD));
endmodule

// File: rtl/smb_hsts_sem.sv
`timescale 1ns/1ps
module smb_hsts_sem
    import smb_hsts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_clr,
    input  logic take_i,
    input  logic free_i,
    output logic busy_o
);
    sem_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= SEM_FREE;
        else if (sync_clr) state_q <= SEM_FREE;
        else               state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE:  if (take_i)            state_d = SEM_TAKEN;
            SEM_TAKEN: if (free_i && !take_i) state_d = SEM_FREE;
            default:                          state_d = SEM_FREE;
        endcase
    end

    always_comb busy_o = (state_q == SEM_TAKEN);

    assert_take_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && free_i && !sync_clr) |=> busy_o);
endmodule

// File: rtl/smb_hsts_reg.sv
`timescale 1ns/1ps
module smb_hsts_reg
    import smb_hsts_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int REG_OFS = 0
) (
    input  logic              clk,
    input  logic              rsm_rst_n,
    input  logic              plat_rst_n,
    input  logic              warm_rst_req,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              byte_evt,
    input  logic              blk_xfer,
    input  logic              last_byte,
    input  logic              buf_en,
    input  logic              hb_xfer,
    input  logic              done_evt,
    input  logic              alert_int,
    input  logic              alert_gpi,
    input  logic              gie,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFS_A = ADDR_W'(REG_OFS);

    logic                hit, rd_hit, wr_hit;
    logic                byte_ok, seq_rel, seq_hold, inuse_q;
    logic                clr_all, clr_plat;
    logic [N_STICKY-1:0] st_set, st_clr, st_sclr, st_q;
    logic [STAT_W-1:0]   status;

    always_comb begin
        hit      = (reg_addr == OFS_A);
        rd_hit   = reg_rd && hit;
        wr_hit   = reg_wr && hit;
        byte_ok  = byte_evt && blk_xfer && !buf_en && !hb_xfer;
        clr_all  = warm_rst_req;
        clr_plat = warm_rst_req || !plat_rst_n;
    end

    // Per-flag set, clear and reset-domain selection.
    always_comb begin
        st_set[IDX_BD]    = byte_ok;
        st_clr[IDX_BD]    = wr_hit && reg_wdata[POS_BD];
        st_sclr[IDX_BD]   = clr_plat;
        st_set[IDX_ALERT] = alert_int && !alert_gpi;
        st_clr[IDX_ALERT] = wr_hit && reg_wdata[POS_ALERT];
        st_sclr[IDX_ALERT]= clr_all;
        st_set[IDX_INTR]  = done_evt || seq_rel;
        st_clr[IDX_INTR]  = wr_hit && reg_wdata[POS_INTR];
        st_sclr[IDX_INTR] = clr_plat;
    end

    for (genvar g = 0; g < N_STICKY; g++) begin : g_flag
        smb_hsts_sticky u_flag (
            .clk      (clk),
            .rst_n    (rsm_rst_n),
            .sync_clr (st_sclr[g]),
            .set_i    (st_set[g]),
            .clr_i    (st_clr[g]),
            .q_o      (st_q[g])
        );
    end

    smb_hsts_seq u_seq (
        .clk        (clk),
        .rst_n      (rsm_rst_n),
        .sync_clr   (clr_plat),
        .last_set_i (byte_ok && last_byte),
        .bd_set_i   (byte_ok),
        .bd_clr_i   (wr_hit && reg_wdata[POS_BD]),
        .release_o  (seq_rel),
        .hold_o     (seq_hold)
    );

    smb_hsts_sem u_sem (
        .clk      (clk),
        .rst_n    (rsm_rst_n),
        .sync_clr (clr_plat),
        .take_i   (rd_hit),
        .free_i   (wr_hit && reg_wdata[POS_INUSE]),
        .busy_o   (inuse_q)
    );

    always_comb begin
        status            = '0;
        status[POS_BD]    = st_q[IDX_BD];
        status[POS_INUSE] = inuse_q;
        status[POS_ALERT] = st_q[IDX_ALERT];
        status[POS_INTR]  = st_q[IDX_INTR];
        reg_rdata         = rd_hit ? status : 8'h00;
        irq               = gie && (st_q[IDX_BD] || st_q[IDX_ALERT] || st_q[IDX_INTR]);
    end

    assert_bd_blocked_R3: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (byte_evt && (buf_en || hb_xfer) && !st_q[IDX_BD]) |=> !st_q[IDX_BD]);

    assert_w0_keeps_bd_R4: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (plat_rst_n && !warm_rst_req && reg_wr && !reg_wdata[POS_BD] && st_q[IDX_BD])
        |=> st_q[IDX_BD]);

    assert_release_intr_R5: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (seq_hold && plat_rst_n && !warm_rst_req && wr_hit && reg_wdata[POS_BD] && !byte_ok)
        |=> st_q[IDX_INTR]);

    assert_inuse_take_R7: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (rd_hit && plat_rst_n && !warm_rst_req) |=> inuse_q);

    assert_alert_gpi_R9: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (alert_gpi && !st_q[IDX_ALERT]) |=> !st_q[IDX_ALERT]);

    assert_alert_plat_R10: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (!plat_rst_n && !warm_rst_req && st_q[IDX_ALERT] && !reg_wr) |=> st_q[IDX_ALERT]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (byte_ok && wr_hit && reg_wdata[POS_BD] && plat_rst_n && !warm_rst_req)
        |=> st_q[IDX_BD]);
endmodule

// File: tb/smb_hsts_reg_tb_top.sv
`timescale 1ns/1ps
module smb_hsts_reg_tb_top;
    logic       clk = 1'b0;
    logic       rsm_rst_n, plat_rst_n, warm_rst_req;
    logic       reg_rd, reg_wr;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       byte_evt, blk_xfer, last_byte, buf_en, hb_xfer, done_evt;
    logic       alert_int, alert_gpi, gie, irq;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    fin = 1'b0;

    bit m_bd, m_in, m_al, m_it, m_hold;

    always #2.5 clk = ~clk;

    smb_hsts_reg dut_i (
        .clk(clk), .rsm_rst_n(rsm_rst_n), .plat_rst_n(plat_rst_n),
        .warm_rst_req(warm_rst_req), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .byte_evt(byte_evt), .blk_xfer(blk_xfer), .last_byte(last_byte),
        .buf_en(buf_en), .hb_xfer(hb_xfer), .done_evt(done_evt),
        .alert_int(alert_int), .alert_gpi(alert_gpi), .gie(gie), .irq(irq)
    );

    // Behavioural reference: clears first, sets second.
    always @(posedge clk or negedge rsm_rst_n) begin : ref_model
        bit qb, w0, rel;
        if (!rsm_rst_n) begin
            m_bd = 0; m_in = 0; m_al = 0; m_it = 0; m_hold = 0;
        end else if (warm_rst_req) begin
            m_bd = 0; m_in = 0; m_al = 0; m_it = 0; m_hold = 0;
        end else begin
            qb = byte_evt && blk_xfer && !buf_en && !hb_xfer;
            w0 = reg_wr && reg_addr == 5'd0;
            if (w0 && reg_wdata[5]) m_al = 0;
            if (alert_int && !alert_gpi) m_al = 1;
            if (!plat_rst_n) begin
                m_bd = 0; m_in = 0; m_it = 0; m_hold = 0;
            end else begin
                rel = m_hold && w0 && reg_wdata[7] && !qb;
                if (w0 && reg_wdata[7]) m_bd = 0;
                if (qb) m_bd = 1;
                if (rel) m_hold = 0;
                else if (qb && last_byte) m_hold = 1;
                if (w0 && reg_wdata[1]) m_it = 0;
                if (done_evt || rel) m_it = 1;
                if (w0 && reg_wdata[6]) m_in = 0;
                if (reg_rd && reg_addr == 5'd0) m_in = 1;
            end
        end
    end

    always @(negedge clk) begin
        logic [7:0] e_rd;
        logic       e_irq;
        if (!fin) begin
            e_rd  = (reg_rd && reg_addr == 5'd0) ?
                    {m_bd, m_in, m_al, 3'b000, m_it, 1'b0} : 8'h00;
            e_irq = gie && (m_bd || m_al || m_it);
            n_chk++;
            if (reg_rdata !== e_rd || irq !== e_irq) begin
                n_err++;
                $display("FAIL %s: rdata=%02h irq=%b expected rdata=%02h irq=%b at %0t",
                         cur_req, reg_rdata, irq, e_rd, e_irq, $time);
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rd(input logic [4:0] a);
        reg_rd = 1; reg_addr = a; tick(); reg_rd = 0; reg_addr = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
        reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    task automatic bytex(input bit last, input bit be, input bit hb);
        byte_evt = 1; blk_xfer = 1; last_byte = last; buf_en = be; hb_xfer = hb;
        tick();
        byte_evt = 0; last_byte = 0; buf_en = 0; hb_xfer = 0;
    endtask

    initial begin
        #(5 * 100000);
        if (!fin) begin
            fin = 1'b1;
            n_err++;
            $display("FAIL R1: watchdog expired, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rsm_rst_n = 0; plat_rst_n = 0; warm_rst_req = 0;
        reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        byte_evt = 0; blk_xfer = 0; last_byte = 0; buf_en = 0; hb_xfer = 0;
        done_evt = 0; alert_int = 0; alert_gpi = 0; gie = 1;
        #12 rsm_rst_n = 1; plat_rst_n = 1;
        tick(2);

        cur_req = "R1";  rd(0);                    // first read 00h
        cur_req = "R7";  rd(0); rd(0); wr(0, 8'h40); rd(0); wr(0, 8'h40);
        cur_req = "R8";  rd(0); tick(2); rd(0);    // in-use set, irq stays low
        wr(0, 8'h40);
        cur_req = "R2";  bytex(0, 0, 0); rd(0); bytex(0, 0, 0); rd(0);
        cur_req = "R4";  wr(0, 8'h00); rd(0); wr(5'd4, 8'hFF); rd(0);
        wr(0, 8'h80); rd(0);
        cur_req = "R3";  bytex(0, 1, 0); rd(0); bytex(0, 0, 1); rd(0);
        cur_req = "R5";  bytex(0, 0, 0); wr(0, 8'h80); bytex(1, 0, 0); rd(0);
        rd(0); wr(0, 8'h80); rd(0); wr(0, 8'h02); rd(0);
        cur_req = "R6";  done_evt = 1; tick(); done_evt = 0; rd(0);
        wr(0, 8'h02); rd(0);
        cur_req = "R9";  alert_int = 1; tick(); alert_int = 0; rd(0);
        wr(0, 8'h20); alert_gpi = 1; alert_int = 1; tick(3);
        alert_int = 0; alert_gpi = 0; rd(0);
        cur_req = "R10"; alert_int = 1; tick(); alert_int = 0;
        bytex(0, 0, 0); rd(0); rd(0);
        plat_rst_n = 0; tick(); plat_rst_n = 1; rd(0);
        bytex(0, 0, 0); warm_rst_req = 1; tick(); warm_rst_req = 0; rd(0);
        cur_req = "R11";
        bytex(0, 0, 0);
        byte_evt = 1; blk_xfer = 1; reg_wr = 1; reg_wdata = 8'h80; tick();
        byte_evt = 0; reg_wr = 0; reg_wdata = 0; rd(0);
        done_evt = 1; reg_wr = 1; reg_wdata = 8'h02; tick();
        done_evt = 0; reg_wr = 0; reg_wdata = 0; rd(0);
        alert_int = 1; reg_wr = 1; reg_wdata = 8'h20; tick();
        alert_int = 0; reg_wr = 0; reg_wdata = 0; rd(0);
        reg_rd = 1; reg_wr = 1; reg_wdata = 8'h40; tick();
        reg_rd = 0; reg_wr = 0; reg_wdata = 0; rd(0);
        wr(0, 8'hFF);
        bytex(1, 0, 0);                            // enter hold
        byte_evt = 1; blk_xfer = 1; reg_wr = 1; reg_wdata = 8'h80; tick();
        byte_evt = 0; reg_wr = 0; reg_wdata = 0; rd(0);  // no release
        wr(0, 8'h80); rd(0);                       // release now
        wr(0, 8'hFF);
        cur_req = "R12"; done_evt = 1; tick(); done_evt = 0;
        gie = 0; tick(2); gie = 1; tick(); wr(0, 8'h02); tick();
        cur_req = "R13"; bytex(0, 0, 0); rd(5'd1); rd(5'd31); rd(0);
        wr(0, 8'hFF); tick(2);

        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule